// File: doc/BRIEF.md
# Fault-Triggered Timed Power Shutdown Controller

This block watches the power rail of a system board. It receives digitized readings of enclosure temperature and input supply voltage, each marked by a sample strobe. It compares every strobed reading against fixed limits. Two faulty readings in a row confirm a fault. The block then raises a warning flag to the host processor and counts down a grace period of one-second ticks. When the grace period ends, it drops the power-enable output and holds it low for a long fixed off interval. It then passes through a one-cycle restart state and resumes monitoring.

The temperature code is signed two's complement, so sub-zero ambient readings sit below the limit and do not trip it. The voltage code is unsigned. It must stay inside an inclusive window. Once a warning has started, the full sequence always runs to the end, even if the reading recovers. This keeps the rail from toggling when a reading hovers near a limit. The tick input is gated by an enable input. All limits and both durations are parameters, so a short bench setting can stand in for the real 60 s and 3 h values.

Top module: `pwr_shutdown_ctrl`

## Requirements
- R1: After reset the block is in the monitoring state (state code 0), with `pwr_en` = 1 and `cpu_warn` = 0.
- R2: A temperature reading is faulty when its signed code is strictly greater than `TEMP_HI`. A code equal to `TEMP_HI` is not faulty.
- R3: Temperature codes are two's complement. A negative code is below the limit and never faulty.
- R4: A voltage reading is faulty when its unsigned code is below `VOLT_LO` or above `VOLT_HI`. Both bounds themselves are allowed.
- R5: A fault is confirmed only on two consecutive strobed samples that are both faulty. A single faulty sample followed by a good one does not trip. Cycles without `sample_vld` are ignored, whatever the codes are.
- R6: The warning state has state code 1, with `cpu_warn` = 1 and `pwr_en` = 1. It is entered on the clock edge that captures the second faulty sample.
- R7: The warning state lasts exactly `WARN_TICKS` qualified ticks, meaning cycles with `tick` and `tick_en` both high. A tick with `tick_en` low is not counted.
- R8: Once warning has begun, the sequence continues even if the readings return inside their limits.
- R9: The off state has state code 2, with `pwr_en` = 0 and `cpu_warn` = 1. It lasts exactly `OFF_TICKS` qualified ticks.
- R10: After the off state, the restart state (state code 3, with `pwr_en` = 1 and `cpu_warn` = 0) lasts one cycle. The block then returns to monitoring (state code 0).
- R11: Faulty samples seen during warning or off do not count toward a new trip. After the return to monitoring, two fresh consecutive faulty samples are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| temp_code | input | TEMP_W | Signed temperature reading |
| volt_code | input | VOLT_W | Unsigned input voltage reading |
| sample_vld | input | 1 | Readings are valid this cycle |
| tick | input | 1 | One-second tick pulse |
| tick_en | input | 1 | Qualifies `tick` |
| cpu_warn | output | 1 | Warning to the host processor |
| pwr_en | output | 1 | Power enable for the supervised rail |
| state_o | output | 2 | Current state: 0 monitor, 1 warn, 2 off, 3 restart |

## Verification
Every output is registered from the next-state logic. A state change therefore shows at the ports on the same rising edge that captures its cause: the second faulty sample, the final qualified tick of a countdown, or the single restart cycle. The bench drives each strobe or tick on a falling edge. It removes the strobe or tick on the next falling edge and reads the ports just after that. Each result is observed one full edge after its stimulus and never at the edge itself. Countdown lengths are checked by reading the ports after every tick: the state must hold until the final tick and change on that tick.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    ST_MONITOR = 2'd0,
    ST_WARN    = 2'd1,
    ST_OFF     = 2'd2,
    ST_RESTART = 2'd3
  } psc_state_e;
endpackage

// File: rtl/psc_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module psc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/psc_fault_qual.sv
// Limit comparison and two-sample confirmation filter.
module psc_fault_qual #(
  parameter int TEMP_W  = 12,
  parameter int VOLT_W  = 12,
  parameter int TEMP_HI = 700,
  parameter int VOLT_LO = 190,
  parameter int VOLT_HI = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [VOLT_W-1:0] volt_code,
  input  logic              sample_vld,
  output logic              confirm
);
  localparam logic signed [TEMP_W-1:0] TEMP_HI_C = TEMP_W'(TEMP_HI);
  localparam logic [VOLT_W-1:0]        VOLT_LO_C = VOLT_W'(VOLT_LO);
  localparam logic [VOLT_W-1:0]        VOLT_HI_C = VOLT_W'(VOLT_HI);

  logic over_temp, volt_out, fault_now;
  logic streak_q, streak_d;

  always_comb begin
    over_temp = $signed(temp_code) > TEMP_HI_C;
    volt_out  = (volt_code < VOLT_LO_C) || (volt_code > VOLT_HI_C);
    fault_now = over_temp || volt_out;
  end

  always_comb begin
    streak_d = streak_q;
    if (!arm)            streak_d = 1'b0;
    else if (sample_vld) streak_d = fault_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) streak_q <= 1'b0;
    else        streak_q <= streak_d;
  end

  assign confirm = arm && sample_vld && fault_now && streak_q;
endmodule

// File: rtl/psc_tick_timer.sv
// Shared countdown of qualified ticks for the warning and off intervals.
module psc_tick_timer #(
  parameter int WARN_TICKS = 60,
  parameter int OFF_TICKS  = 10800,
  localparam int MAX_TICKS = (WARN_TICKS > OFF_TICKS) ? WARN_TICKS : OFF_TICKS,
  localparam int CW        = $clog2(MAX_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_off,
  input  logic tick_q,
  output logic expire
);
  localparam logic [CW-1:0] WARN_LAST = CW'(WARN_TICKS - 1);
  localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last   = sel_off ? OFF_LAST : WARN_LAST;
    expire = run && tick_q && (cnt_q == last);
    cnt_d  = cnt_q;
    if (!run || expire) cnt_d = '0;
    else if (tick_q)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psc_seq_fsm.sv
// Sequencer: monitor -> warn -> off -> restart -> monitor, registered outputs.
module psc_seq_fsm
  import psc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       confirm,
  input  logic       expire,
  output logic       arm,
  output logic       run,
  output logic       sel_off,
  output logic       cpu_warn,
  output logic       pwr_en,
  output logic [1:0] state_o
);
  psc_state_e state_q, state_d;
  logic       warn_d, pwr_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_MONITOR: if (confirm) state_d = ST_WARN;
      ST_WARN:    if (expire)  state_d = ST_OFF;
      ST_OFF:     if (expire)  state_d = ST_RESTART;
      ST_RESTART: state_d = ST_MONITOR;
      default:    state_d = ST_MONITOR;
    endcase
    warn_d = (state_d == ST_WARN) || (state_d == ST_OFF);
    pwr_d  = (state_d != ST_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_MONITOR;
      cpu_warn <= 1'b0;
      pwr_en   <= 1'b1;
    end else begin
      state_q  <= state_d;
      cpu_warn <= warn_d;
      pwr_en   <= pwr_d;
    end
  end

  assign arm     = (state_q == ST_MONITOR);
  assign run     = (state_q == ST_WARN) || (state_q == ST_OFF);
  assign sel_off = (state_q == ST_OFF);
  assign state_o = state_q;
endmodule

// File: rtl/pwr_shutdown_ctrl.sv
module pwr_shutdown_ctrl #(
  parameter int TEMP_W     = 12,
  parameter int VOLT_W     = 12,
  parameter int TEMP_HI    = 700,
  parameter int VOLT_LO    = 190,
  parameter int VOLT_HI    = 300,
  parameter int WARN_TICKS = 60,
  parameter int OFF_TICKS  = 10800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [VOLT_W-1:0] volt_code,
  input  logic              sample_vld,
  input  logic              tick,
  input  logic              tick_en,
  output logic              cpu_warn,
  output logic              pwr_en,
  output logic [1:0]        state_o
);
  logic rst_n_s, arm, run, sel_off, confirm, expire, tick_q;

  assign tick_q = tick && tick_en;

  psc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  psc_fault_qual #(
    .TEMP_W(TEMP_W), .VOLT_W(VOLT_W), .TEMP_HI(TEMP_HI),
    .VOLT_LO(VOLT_LO), .VOLT_HI(VOLT_HI)
  ) u_qual (
    .clk(clk), .rst_n(rst_n_s), .arm(arm), .temp_code(temp_code),
    .volt_code(volt_code), .sample_vld(sample_vld), .confirm(confirm)
  );

  psc_tick_timer #(.WARN_TICKS(WARN_TICKS), .OFF_TICKS(OFF_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .run(run), .sel_off(sel_off),
    .tick_q(tick_q), .expire(expire)
  );

  psc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .confirm(confirm), .expire(expire),
    .arm(arm), .run(run), .sel_off(sel_off), .cpu_warn(cpu_warn),
    .pwr_en(pwr_en), .state_o(state_o)
  );
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int WARN_TICKS = 60,
  parameter int OFF_TICKS  = 10800,
  localparam int MAXT = (WARN_TICKS > OFF_TICKS) ? WARN_TICKS : OFF_TICKS,
  localparam int KW   = $clog2(MAXT + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_vld,
  input logic       tick,
  input logic       tick_en,
  input logic       cpu_warn,
  input logic       pwr_en,
  input logic [1:0] state_o
);
  logic          qt;
  logic [KW-1:0] warn_k, off_k;

  assign qt = tick && tick_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_k <= '0;
      off_k  <= '0;
    end else begin
      if (state_o == 2'd0)             warn_k <= '0;
      else if (state_o == 2'd1 && qt)  warn_k <= warn_k + 1'b1;
      if (state_o == 2'd0)             off_k  <= '0;
      else if (state_o == 2'd2 && qt)  off_k  <= off_k + 1'b1;
    end
  end

  // R1
  monitor_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |-> (pwr_en && !cpu_warn));
  // R9
  off_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (cpu_warn && state_o == 2'd2));
  // R5
  warn_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_warn) |-> $past(sample_vld));
  // R7
  warn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !qt) |=> (state_o == 2'd1));
  // R7
  warn_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && $past(state_o) == 2'd1) |-> (warn_k == KW'(WARN_TICKS)));
  // R9
  off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |-> (off_k == KW'(OFF_TICKS)));
  // R10
  restart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |=> (state_o == 2'd0 && pwr_en && !cpu_warn));
  // R8
  warn_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |=> (state_o == 2'd1 || state_o == 2'd2));
endmodule

bind pwr_shutdown_ctrl psc_checker #(
  .WARN_TICKS(WARN_TICKS), .OFF_TICKS(OFF_TICKS)
) u_psc_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .tick(tick),
  .tick_en(tick_en), .cpu_warn(cpu_warn), .pwr_en(pwr_en), .state_o(state_o)
);

// File: tb/tb_pwr_shutdown_ctrl.sv
module tb_pwr_shutdown_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 12, VW = 12;
  localparam int THI = 700, VLO = 190, VHI = 300;
  localparam int WT = 4, OT = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] temp_code = '0;
  logic [VW-1:0] volt_code = '0;
  logic          sample_vld = 1'b0;
  logic          tick = 1'b0;
  logic          tick_en = 1'b0;
  logic          cpu_warn, pwr_en;
  logic [1:0]    state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_shutdown_ctrl #(
    .TEMP_W(TW), .VOLT_W(VW), .TEMP_HI(THI), .VOLT_LO(VLO), .VOLT_HI(VHI),
    .WARN_TICKS(WT), .OFF_TICKS(OT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .volt_code(volt_code),
    .sample_vld(sample_vld), .tick(tick), .tick_en(tick_en),
    .cpu_warn(cpu_warn), .pwr_en(pwr_en), .state_o(state_o)
  );

  task automatic chk(string req, logic [1:0] es, logic ep, logic ew);
    #1;
    n_chk++;
    if (state_o !== es || pwr_en !== ep || cpu_warn !== ew) begin
      n_fail++;
      $display("FAIL %s: state=%0d pwr_en=%0b cpu_warn=%0b expected state=%0d pwr_en=%0b cpu_warn=%0b",
               req, state_o, pwr_en, cpu_warn, es, ep, ew);
    end
  endtask

  task automatic sample(int t, int v);
    @(negedge clk);
    temp_code  = TW'(t);
    volt_code  = VW'(v);
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic pulse_tick(bit en);
    @(negedge clk);
    tick    = 1'b1;
    tick_en = en;
    @(negedge clk);
    tick    = 1'b0;
    tick_en = 1'b0;
  endtask

  task automatic run_out();
    for (int i = 0; i < WT + OT; i++) pulse_tick(1'b1);
    @(negedge clk);
    chk("R10 back to monitor", 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_noise();
    sample(800, 250);
    chk("R5 single fault", 2'd0, 1'b1, 1'b0);
    sample(250, 250);
    sample(800, 250);
    chk("R5 fault after good", 2'd0, 1'b1, 1'b0);
    sample(250, 250);
    @(negedge clk);
    temp_code = TW'(900);
    repeat (10) @(negedge clk);
    chk("R5 no strobe ignored", 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_temp_limits();
    sample(-200, 250);
    sample(-200, 250);
    chk("R3 negative temp", 2'd0, 1'b1, 1'b0);
    sample(-2000, 250);
    sample(-1, 250);
    chk("R3 large negative", 2'd0, 1'b1, 1'b0);
    sample(THI, 250);
    sample(THI, 250);
    chk("R2 at limit", 2'd0, 1'b1, 1'b0);
    sample(THI + 1, 250);
    repeat (3) @(negedge clk);
    sample(THI + 1, 250);
    chk("R2 R6 over limit trips", 2'd1, 1'b1, 1'b1);
  endtask

  task automatic t_sequence();
    // still in WARN from previous task; fault clears and gated ticks ignored
    sample(250, 250);
    chk("R8 fault cleared", 2'd1, 1'b1, 1'b1);
    pulse_tick(1'b0);
    pulse_tick(1'b0);
    chk("R7 ungated tick ignored", 2'd1, 1'b1, 1'b1);
    sample(900, 250);
    sample(900, 250);
    for (int i = 0; i < WT - 1; i++) pulse_tick(1'b1);
    chk("R7 warn before last tick", 2'd1, 1'b1, 1'b1);
    pulse_tick(1'b1);
    chk("R9 off entered", 2'd2, 1'b0, 1'b1);
    sample(900, 100);
    pulse_tick(1'b0);
    for (int i = 0; i < OT - 1; i++) pulse_tick(1'b1);
    chk("R9 off before last tick", 2'd2, 1'b0, 1'b1);
    sample(900, 100);
    @(negedge clk);
    temp_code  = TW'(900);
    sample_vld = 1'b0;
    tick = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    tick = 1'b0; tick_en = 1'b0;
    chk("R10 restart cycle", 2'd3, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10 monitor after restart", 2'd0, 1'b1, 1'b0);
    sample(900, 250);
    chk("R11 no carried streak", 2'd0, 1'b1, 1'b0);
    sample(250, 250);
  endtask

  task automatic t_volt_limits();
    sample(250, VLO);
    sample(250, VLO);
    chk("R4 at low bound", 2'd0, 1'b1, 1'b0);
    sample(250, VHI);
    sample(250, VHI);
    chk("R4 at high bound", 2'd0, 1'b1, 1'b0);
    sample(250, VLO - 1);
    sample(250, VLO - 1);
    chk("R4 under low trips", 2'd1, 1'b1, 1'b1);
    run_out();
    sample(250, VHI + 1);
    sample(250, VHI + 1);
    chk("R4 over high trips", 2'd1, 1'b1, 1'b1);
    run_out();
    sample(800, 250);
    sample(250, 4000);
    chk("R5 mixed faults trip", 2'd1, 1'b1, 1'b1);
    run_out();
  endtask

  initial begin
    t_reset();
    t_noise();
    t_temp_limits();
    t_sequence();
    t_volt_limits();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule